// File: doc/BRIEF.md
# Transposed Line-Buffer Sub-Image Extractor

The block receives a bit-serial stream of binary pixels from a linear image sensor. Each pixel comes with its own pixel clock and a column address. Pixels fill a row from column 0 up to column `COLS-1`, and the rows follow one after another. The block keeps the last `ROWS` rows in a single RAM of `COLS` words, each `ROWS` bits wide, addressed by column. Each word holds the recent history of one column, with one bit for each row. Each incoming pixel therefore changes exactly one bit of one word, through a read-modify-write sequence run on a faster system clock.

After every pixel, the updated column word is rotated so that its newest row comes first. It is then shifted into a `ROWS` x `WIN_W` register window. The window slides right by one column per pixel and always ends at the column just written. A one-cycle valid pulse marks each new window. A sticky flag reports when every row of the history has been written once. Until that flag is set, the rows of the window that come from unwritten RAM hold no defined value.

Top module: `sub_image_extractor`

## Requirements
- R1: While `rst_ni` is low, `win_o`, `win_valid_o` and `hist_full_o` are 0. Reset also returns the row pointer to 0 and the previous-column record to 0. RAM contents are left untouched.
- R2: Each rising edge of `pix_clk_i` produces exactly one window update, marked by one `win_valid_o` pulse within 12 system clocks of the edge. This holds when each pixel-clock phase lasts at least 5 system clocks and data and address stay stable around the rising edge.
- R3: The pixel value is written into bit `ptr` of the RAM word at address `pix_addr_i`, where `ptr` is the row pointer. It then appears at window row 0, newest column, which is bit `0*WIN_W + WIN_W-1` of `win_o`.
- R4: A pixel update leaves the other `ROWS-1` bits of the addressed word unchanged.
- R5: On each update, window column c takes the former contents of column c+1. Column `WIN_W-1` receives the new column. Bit `r*WIN_W + c` of `win_o` is row r, column c.
- R6: The row pointer advances by one, modulo `ROWS`, only when a pixel at column 0 directly follows a pixel at column `COLS-1`. Any other address sequence, including a restart at column 0 mid-row, keeps the pointer unchanged.
- R7: When a column is inserted, window row k receives bit `(ptr - k) mod ROWS` of the updated word. Row 0 is therefore the newest row.
- R8: `hist_full_o` rises after a pixel at column `COLS-1` is written while the row pointer equals `ROWS-1`. It stays high until reset.
- R9: `win_valid_o` is high for exactly one system clock per update. `win_o` holds its value between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, about 10x the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_clk_i | input | 1 | Pixel clock; a pixel is taken on its rising edge |
| pix_data_i | input | 1 | Binary pixel value |
| pix_addr_i | input | $clog2(COLS) | Column of the pixel |
| win_o | output | ROWS*WIN_W | Window, bit r*WIN_W+c = row r (0 newest), column c (WIN_W-1 newest) |
| win_valid_o | output | 1 | One-cycle pulse per new window |
| hist_full_o | output | 1 | Every history row has been written once |

## Verification
The bench builds the block with `COLS=8`, `ROWS=4` and `WIN_W=5`. With these values a row wraps every 8 pixels and the history fills after 32 pixels. Within a short run, the row pointer wraps past `ROWS-1` more than once, and the 5-wide window regularly spans the boundary between two rows. The window being wider than the history is tall also shows whether rows and columns are mixed up. A reference model tracks which RAM bits are known, so every window is compared from the first pixel on. This includes the windows after a mid-run reset, where old RAM contents meet a fresh row pointer.

// File: rtl/sie_pkg.sv
package sie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MODW  = 2'd2,
    ST_SHIFT = 2'd3
  } sie_state_e;
endpackage

// File: rtl/sie_pix_sync.sv
module sie_pix_sync #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          pdata_i,
  input  logic [AW-1:0] paddr_i,
  output logic          stb_o,
  output logic          data_o,
  output logic [AW-1:0] addr_o
);
  logic [2:0]    pclk_sr_q;
  logic [1:0]    data_sr_q;
  logic [AW-1:0] addr_s1_q, addr_s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_sr_q <= '0;
      data_sr_q <= '0;
      addr_s1_q <= '0;
      addr_s2_q <= '0;
    end else begin
      pclk_sr_q <= {pclk_sr_q[1:0], pclk_i};
      data_sr_q <= {data_sr_q[0], pdata_i};
      addr_s1_q <= paddr_i;
      addr_s2_q <= addr_s1_q;
    end
  end

  // rising edge of the synchronized pixel clock
  assign stb_o  = pclk_sr_q[1] & ~pclk_sr_q[2];
  assign data_o = data_sr_q[1];
  assign addr_o = addr_s2_q;

  a_r2_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/sie_col_ram.sv
module sie_col_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sie_rmw_ctrl.sv
module sie_rmw_ctrl
  import sie_pkg::*;
#(
  parameter int COLS  = 1024,
  parameter int ROWS  = 16,
  localparam int AW   = $clog2(COLS),
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic            data_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [ROWS-1:0] ram_rdata_i,
  output logic            ram_re_o,
  output logic [AW-1:0]   ram_raddr_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_waddr_o,
  output logic [ROWS-1:0] ram_wdata_o,
  output logic            shift_o,
  output logic [ROWS-1:0] col_o,
  output logic            full_o
);
  localparam logic [AW-1:0] LAST_COL = AW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  sie_state_e      state_q;
  logic [RW-1:0]   ptr_q, ptr_nxt;
  logic [AW-1:0]   prev_q, cap_addr_q;
  logic            cap_data_q;
  logic [ROWS-1:0] word_q, mod_word;
  logic            full_q;
  logic            accept;

  assign accept = (state_q == ST_IDLE) && stb_i;

  always_comb begin
    ptr_nxt = ptr_q;
    if (addr_i == '0 && prev_q == LAST_COL)
      ptr_nxt = (ptr_q == LAST_ROW) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    mod_word        = ram_rdata_i;
    mod_word[ptr_q] = cap_data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      prev_q     <= '0;
      cap_addr_q <= '0;
      cap_data_q <= 1'b0;
      word_q     <= '0;
      full_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (stb_i) begin
          cap_addr_q <= addr_i;
          cap_data_q <= data_i;
          prev_q     <= addr_i;
          ptr_q      <= ptr_nxt;
          state_q    <= ST_READ;
        end
        ST_READ: state_q <= ST_MODW;
        ST_MODW: begin
          word_q <= mod_word;
          if (cap_addr_q == LAST_COL && ptr_q == LAST_ROW) full_q <= 1'b1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_re_o    = (state_q == ST_READ);
  assign ram_raddr_o = cap_addr_q;
  assign ram_we_o    = (state_q == ST_MODW);
  assign ram_waddr_o = cap_addr_q;
  assign ram_wdata_o = mod_word;
  assign shift_o     = (state_q == ST_SHIFT);
  assign full_o      = full_q;

  // rotate so that output row 0 is the newest row
  always_comb begin
    for (int k = 0; k < ROWS; k++) begin
      int i;
      i = int'(ptr_q) - k;
      if (i < 0) i = i + ROWS;
      col_o[k] = word_q[RW'(i)];
    end
  end

  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(ptr_q));
  a_r8_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> full_q);
  a_r4_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ($countones(ram_wdata_o ^ ram_rdata_i) <= 1));
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !(ram_re_o && ram_we_o));
endmodule

// File: rtl/sie_win_shift.sv
module sie_win_shift #(
  parameter int ROWS  = 16,
  parameter int WIN_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic [ROWS-1:0]       col_i,
  output logic [ROWS*WIN_W-1:0] win_o,
  output logic                  valid_o
);
  logic [ROWS-1:0] cols_q [WIN_W];
  logic            valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < WIN_W; c++) cols_q[c] <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= shift_i;
      if (shift_i) begin
        for (int c = 0; c < WIN_W - 1; c++) cols_q[c] <= cols_q[c+1];
        cols_q[WIN_W-1] <= col_i;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < WIN_W; c++) begin : g_col
      assign win_o[r*WIN_W + c] = cols_q[c][r];
    end
  end

  assign valid_o = valid_q;

  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r9_win_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(win_o));
  a_r3_new_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (cols_q[WIN_W-1] == $past(col_i)));
  if (WIN_W > 1) begin : g_slide_chk
    a_r5_slide: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> (cols_q[0] == $past(cols_q[1])));
  end
endmodule

// File: rtl/sub_image_extractor.sv
module sub_image_extractor #(
  parameter int COLS  = 1024,
  parameter int ROWS  = 16,
  parameter int WIN_W = 16,
  localparam int AW   = $clog2(COLS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pix_clk_i,
  input  logic                  pix_data_i,
  input  logic [AW-1:0]         pix_addr_i,
  output logic [ROWS*WIN_W-1:0] win_o,
  output logic                  win_valid_o,
  output logic                  hist_full_o
);
  logic            stb, sdata;
  logic [AW-1:0]   saddr;
  logic            re, we, shift;
  logic [AW-1:0]   raddr, waddr;
  logic [ROWS-1:0] rdata, wdata, col;

  sie_pix_sync #(.AW(AW)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pclk_i(pix_clk_i), .pdata_i(pix_data_i), .paddr_i(pix_addr_i),
    .stb_o(stb), .data_o(sdata), .addr_o(saddr)
  );

  sie_col_ram #(.DEPTH(COLS), .WIDTH(ROWS)) u_ram (
    .clk_i(clk_i),
    .re_i(re), .raddr_i(raddr),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .rdata_o(rdata)
  );

  sie_rmw_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stb_i(stb), .data_i(sdata), .addr_i(saddr),
    .ram_rdata_i(rdata),
    .ram_re_o(re), .ram_raddr_o(raddr),
    .ram_we_o(we), .ram_waddr_o(waddr), .ram_wdata_o(wdata),
    .shift_o(shift), .col_o(col), .full_o(hist_full_o)
  );

  sie_win_shift #(.ROWS(ROWS), .WIN_W(WIN_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .shift_i(shift), .col_i(col),
    .win_o(win_o), .valid_o(win_valid_o)
  );

  a_r2_valid_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> !win_valid_o);
endmodule

// File: tb/sub_image_extractor_tb_top.sv
module sub_image_extractor_tb_top;
  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int W    = 5;
  localparam int AW   = $clog2(COLS);
  localparam int NB   = ROWS * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_clk = 1'b0;
  logic          pix_data = 1'b0;
  logic [AW-1:0] pix_addr = '0;
  logic [NB-1:0] win;
  logic          win_valid, hist_full;

  always #4 clk = ~clk;

  sub_image_extractor #(.COLS(COLS), .ROWS(ROWS), .WIN_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_clk_i(pix_clk), .pix_data_i(pix_data), .pix_addr_i(pix_addr),
    .win_o(win), .win_valid_o(win_valid), .hist_full_o(hist_full)
  );

  int vectors = 0, fails = 0, vcnt = 0;
  bit done = 0;

  // reference model
  logic [ROWS-1:0] m_val [COLS];
  logic [ROWS-1:0] m_kn  [COLS];
  logic [NB-1:0]   e_win, e_kn;
  int ptr, prev;
  bit e_full;

  always @(posedge clk) if (win_valid) vcnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    ptr = 0; prev = 0; e_full = 0;
    e_win = '0; e_kn = '1;
  endtask

  task automatic t_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    pix_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk(win == '0, req, "window in reset", 64'(win), 64'h0);
    chk(win_valid == 1'b0 && hist_full == 1'b0, req, "valid/full in reset",
        {win_valid, hist_full}, 64'h0);
    model_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input int a, input bit d, input string req);
    int v0;
    if (a == 0 && prev == COLS - 1) ptr = (ptr + 1) % ROWS;
    prev = a;
    m_val[a][ptr] = d;
    m_kn[a][ptr]  = 1'b1;
    if (a == COLS - 1 && ptr == ROWS - 1) e_full = 1;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < W - 1; c++) begin
        e_win[r*W + c] = e_win[r*W + c + 1];
        e_kn[r*W + c]  = e_kn[r*W + c + 1];
      end
      e_win[r*W + W - 1] = m_val[a][(ptr - r + ROWS) % ROWS];
      e_kn[r*W + W - 1]  = m_kn[a][(ptr - r + ROWS) % ROWS];
    end
    @(negedge clk);
    pix_addr = AW'(a);
    pix_data = d;
    repeat (6) @(negedge clk);
    v0 = vcnt;
    pix_clk = 1'b1;
    repeat (6) @(negedge clk);
    pix_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk(vcnt - v0 == 1, "R2 R9", "valid cycles per pixel", 64'(vcnt - v0), 64'd1);
    chk(((win ^ e_win) & e_kn) == '0, req, "window", 64'(win & e_kn), 64'(e_win & e_kn));
    chk(hist_full == e_full, "R8", "history full flag", 64'(hist_full), 64'(e_full));
  endtask

  task automatic t_fill(input int nrows, input int salt);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++)
        push(c, bit'((c + r + salt) % 3 == 0), "R3 R4 R5 R7");
  endtask

  task automatic t_random(input int nrows);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++)
        push(c, bit'($urandom_range(0, 1)), "R3 R4 R5 R7");
  endtask

  task automatic t_restart();
    int p0;
    for (int c = 0; c < 4; c++) push(c, 1'b1, "R6");
    p0 = ptr;
    push(0, 1'b0, "R6");
    chk(ptr == p0, "R6", "model pointer held", 64'(ptr), 64'(p0));
    chk(win[W-1] == 1'b0, "R6", "newest pixel after restart", 64'(win[W-1]), 64'h0);
    chk(win[W + W - 1] == m_val[0][(p0 + ROWS - 1) % ROWS], "R6",
        "previous row kept", 64'(win[W + W - 1]), 64'(m_val[0][(p0 + ROWS - 1) % ROWS]));
    for (int c = 1; c < COLS; c++) push(c, bit'(c & 1), "R6 R3");
  endtask

  initial begin
    for (int i = 0; i < COLS; i++) begin m_val[i] = '0; m_kn[i] = '0; end
    model_reset();
    t_reset("R1");
    t_fill(ROWS, 0);
    t_random(3);
    t_restart();
    t_fill(1, 1);
    t_reset("R1");
    t_fill(ROWS + 1, 2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule